// File: doc/BRIEF.md
# Paired-ring memory copy engine

This block moves data from one memory region to another under the control of two descriptor rings that share a single index. For slot `i`, the transmit ring holds the source address and byte length, and the receive ring holds the destination address. The host fills both entries for a slot and then advances the transmit CPU index. The engine works through the slots from its own DMA index up to that CPU index. It copies each slot one 32-bit word per memory access. When a slot is finished, the engine can write a done flag and the length back into the receive entry, and it raises a receive-done status bit that can drive an interrupt.

Each descriptor occupies 16 bytes at `base + 16*i`. Word 0 is the address. Word 1 carries the length in bits [29:16]. The host reclaims finished slots by moving the receive CPU index forward. The engine never starts the slot that index points at, so at least one slot always stays unused. Software uses a 32-bit register port with a 12-bit address. The engine itself is a memory master with a request/acknowledge handshake that moves one word per transfer.

Top module: `ring_copy_engine`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `mem_req` is low.
- R2: The register map is: TX base 0x000, TX count 0x004, TX CPU index 0x008, TX DMA index 0x00C, and the matching RX registers at 0x100, 0x104, 0x108 and 0x10C. Base, count and CPU index read back what was written. The control register at 0x204 stores TX enable (bit 0), RX enable (bit 2), a burst field (bits 5:4), the writeback enable (bit 6) and bit 10. Its bits 1 and 3 are read-only and report busy.
- R3: For slot `i`, the engine reads the source from TX word 0 and the length from TX word 1 [29:16], and the destination from RX word 0. It then copies length/4 words from source to destination. The word after the last copied word is not touched, and a zero length copies nothing.
- R4: Slots are processed while the TX DMA index differs from the TX CPU index. Both DMA indices advance by one for each slot and wrap to 0 at the TX count.
- R5: A slot whose index equals the RX CPU index is never started, and its destination stays unwritten.
- R6: With writeback enabled (bit 6), RX word 1 of the finished slot becomes `length<<16` with the done flag set: bit 31 when `FLAG_HI` is 1, otherwise bit 15. With writeback disabled, RX word 1 is left as it was.
- R7: Bits of TX word 1 outside [29:16], such as the last-segment flag at bit 30, do not change the copied length.
- R8: Status register 0x220 bit 16 sets when a slot finishes and clears when 1 is written to it. `irq` equals that bit ANDed with bit 16 of enable register 0x228.
- R9: A slot starts only while both TX and RX enable are set. Clearing an enable lets the slot in flight complete, then busy drops and no further slot is fetched.
- R10: Writing 1 to bit 0 of 0x208 returns the TX DMA index to 0. Writing 1 to bit 16 of 0x208 returns the RX DMA index to 0.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access accepted; read data valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| irq | output | 1 | Receive-done interrupt |

## Verification
A sweep over slots whose lengths run from 0 to 6 words tells apart errors in the word count, off-by-one overruns (caught by a sentinel word after each destination) and wrong handling of an empty slot. The same sweep sets junk flag bits in the length word to show they are masked. A second pass wraps the index around the ring while the receive CPU index holds back one slot. This separates correct wrap handling from an engine that overruns reclaimed space. The last passes disable the engine before a slot and during a 15-word slot, turn writeback off, and pulse the index resets. Each of these leaves a different visible trace in memory or in the index registers.

// File: rtl/rce_pkg.sv
package rce_pkg;

  localparam logic [11:0] A_TX_BASE = 12'h000;
  localparam logic [11:0] A_TX_CNT  = 12'h004;
  localparam logic [11:0] A_TX_CPU  = 12'h008;
  localparam logic [11:0] A_TX_DMA  = 12'h00C;
  localparam logic [11:0] A_RX_BASE = 12'h100;
  localparam logic [11:0] A_RX_CNT  = 12'h104;
  localparam logic [11:0] A_RX_CPU  = 12'h108;
  localparam logic [11:0] A_RX_DMA  = 12'h10C;
  localparam logic [11:0] A_CTRL    = 12'h204;
  localparam logic [11:0] A_IDXRST  = 12'h208;
  localparam logic [11:0] A_STAT    = 12'h220;
  localparam logic [11:0] A_INTEN   = 12'h228;

  typedef enum logic [2:0] {
    S_IDLE, S_SRC, S_LEN, S_DST, S_RD, S_WR, S_WB, S_ADV
  } eng_state_t;

  // byte address of ring slot idx
  function automatic logic [31:0] slot_addr(input logic [31:0] base, input logic [31:0] idx);
    return base + (idx << 4);
  endfunction

  // length field of descriptor word 1
  function automatic logic [13:0] len_field(input logic [31:0] w);
    return w[29:16];
  endfunction

  // completion word written back into the receive slot
  function automatic logic [31:0] done_word(input logic [13:0] len, input bit hi);
    logic [31:0] w;
    w = {2'b00, len, 16'h0000};
    if (hi) w[31] = 1'b1;
    else    w[15] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/rce_regs.sv
module rce_regs
  import rce_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [11:0]      reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             eng_busy,
  input  logic             eng_adv,
  output logic [31:0]      tx_base,
  output logic [31:0]      rx_base,
  output logic [CNT_W-1:0] tx_cnt,
  output logic [IDX_W-1:0] tx_cpu,
  output logic [IDX_W-1:0] rx_cpu,
  output logic [IDX_W-1:0] tx_dma,
  output logic             tx_en,
  output logic             rx_en,
  output logic             wb_en,
  output logic             irq
);

  logic [CNT_W-1:0] rx_cnt_q;
  logic [IDX_W-1:0] rx_dma_q;
  logic [1:0]       burst_q;
  logic             multi_q;
  logic             rxdone_q;
  logic             inten_q;
  logic             wr_rst, wr_stat;

  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] i,
                                                 input logic [CNT_W-1:0] n);
    logic [CNT_W-1:0] s;
    s = {1'b0, i} + CNT_W'(1);
    return (s >= n) ? '0 : s[IDX_W-1:0];
  endfunction

  assign wr_rst  = reg_wr && (reg_addr == A_IDXRST);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_base <= '0; rx_base <= '0; tx_cnt <= '0; rx_cnt_q <= '0;
      tx_cpu <= '0; rx_cpu <= '0;
      tx_en <= 1'b0; rx_en <= 1'b0; wb_en <= 1'b0;
      burst_q <= '0; multi_q <= 1'b0; inten_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_TX_BASE: tx_base  <= reg_wdata;
        A_TX_CNT:  tx_cnt   <= reg_wdata[CNT_W-1:0];
        A_TX_CPU:  tx_cpu   <= reg_wdata[IDX_W-1:0];
        A_RX_BASE: rx_base  <= reg_wdata;
        A_RX_CNT:  rx_cnt_q <= reg_wdata[CNT_W-1:0];
        A_RX_CPU:  rx_cpu   <= reg_wdata[IDX_W-1:0];
        A_CTRL: begin
          tx_en   <= reg_wdata[0];
          rx_en   <= reg_wdata[2];
          burst_q <= reg_wdata[5:4];
          wb_en   <= reg_wdata[6];
          multi_q <= reg_wdata[10];
        end
        A_INTEN:   inten_q <= reg_wdata[16];
        default: ;
      endcase
    end
  end

  // DMA indices and completion status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_dma   <= '0;
      rx_dma_q <= '0;
      rxdone_q <= 1'b0;
    end else begin
      if (wr_rst && reg_wdata[0])       tx_dma <= '0;
      else if (eng_adv)                 tx_dma <= ring_next(tx_dma, tx_cnt);
      if (wr_rst && reg_wdata[16])      rx_dma_q <= '0;
      else if (eng_adv)                 rx_dma_q <= ring_next(rx_dma_q, tx_cnt);
      if (eng_adv)                      rxdone_q <= 1'b1;
      else if (wr_stat && reg_wdata[16]) rxdone_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TX_BASE: reg_rdata = tx_base;
      A_TX_CNT:  reg_rdata = 32'(tx_cnt);
      A_TX_CPU:  reg_rdata = 32'(tx_cpu);
      A_TX_DMA:  reg_rdata = 32'(tx_dma);
      A_RX_BASE: reg_rdata = rx_base;
      A_RX_CNT:  reg_rdata = 32'(rx_cnt_q);
      A_RX_CPU:  reg_rdata = 32'(rx_cpu);
      A_RX_DMA:  reg_rdata = 32'(rx_dma_q);
      A_CTRL: begin
        reg_rdata[0]   = tx_en;
        reg_rdata[1]   = eng_busy;
        reg_rdata[2]   = rx_en;
        reg_rdata[3]   = eng_busy;
        reg_rdata[5:4] = burst_q;
        reg_rdata[6]   = wb_en;
        reg_rdata[10]  = multi_q;
      end
      A_STAT:    reg_rdata[16] = rxdone_q;
      A_INTEN:   reg_rdata[16] = inten_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = rxdone_q & inten_q;

  AST_DONE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_adv |=> rxdone_q); // R8

endmodule

// File: rtl/rce_engine.sv
module rce_engine
  import rce_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter bit FLAG_HI = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_ok,
  input  logic             wb_en,
  input  logic [31:0]      tx_base,
  input  logic [31:0]      rx_base,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [IDX_W-1:0] tx_cpu,
  input  logic [IDX_W-1:0] rx_cpu,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             busy,
  output logic             adv
);

  eng_state_t       state;
  eng_state_t       tail_state;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      tb_q, rb_q, src_q, dst_q, data_q;
  logic [13:0]      len_q;
  logic [11:0]      off_q;
  logic [11:0]      words;
  logic             slot_ready;

  assign words      = len_q[13:2];
  assign tail_state = wb_en ? S_WB : S_ADV;
  assign slot_ready = run_ok && (cur_idx != tx_cpu) && (cur_idx != rx_cpu);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx_q <= '0; tb_q <= '0; rb_q <= '0;
      src_q <= '0; dst_q <= '0; data_q <= '0;
      len_q <= '0; off_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (slot_ready) begin
          idx_q <= cur_idx;
          tb_q  <= tx_base;
          rb_q  <= rx_base;
          state <= S_SRC;
        end
        S_SRC: if (mem_ack) begin
          src_q <= mem_rdata;
          state <= S_LEN;
        end
        S_LEN: if (mem_ack) begin
          len_q <= len_field(mem_rdata);
          state <= S_DST;
        end
        S_DST: if (mem_ack) begin
          dst_q <= mem_rdata;
          off_q <= '0;
          state <= (words == '0) ? tail_state : S_RD;
        end
        S_RD: if (mem_ack) begin
          data_q <= mem_rdata;
          state  <= S_WR;
        end
        S_WR: if (mem_ack) begin
          off_q <= off_q + 12'd1;
          state <= ((off_q + 12'd1) == words) ? tail_state : S_RD;
        end
        S_WB:  if (mem_ack) state <= S_ADV;
        S_ADV: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_SRC: mem_addr = slot_addr(tb_q, 32'(idx_q));
      S_LEN: mem_addr = slot_addr(tb_q, 32'(idx_q)) + 32'd4;
      S_DST: mem_addr = slot_addr(rb_q, 32'(idx_q));
      S_RD:  mem_addr = src_q + 32'({off_q, 2'b00});
      S_WR: begin
        mem_we    = 1'b1;
        mem_addr  = dst_q + 32'({off_q, 2'b00});
        mem_wdata = data_q;
      end
      S_WB: begin
        mem_we    = 1'b1;
        mem_addr  = slot_addr(rb_q, 32'(idx_q)) + 32'd4;
        mem_wdata = done_word(len_q, FLAG_HI);
      end
      default: mem_req = 1'b0;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign adv  = (state == S_ADV);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
  AST_BUSY_ENDS_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(adv)); // R9

endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine
  import rce_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter bit FLAG_HI = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        irq
);

  localparam int CNT_W = IDX_W + 1;

  logic [31:0]      tx_base, rx_base;
  logic [CNT_W-1:0] tx_cnt;
  logic [IDX_W-1:0] tx_cpu, rx_cpu, tx_dma;
  logic             tx_en, rx_en, wb_en;
  logic             eng_busy, eng_adv;

  rce_regs #(.IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_busy(eng_busy), .eng_adv(eng_adv),
    .tx_base(tx_base), .rx_base(rx_base), .tx_cnt(tx_cnt),
    .tx_cpu(tx_cpu), .rx_cpu(rx_cpu), .tx_dma(tx_dma),
    .tx_en(tx_en), .rx_en(rx_en), .wb_en(wb_en), .irq(irq)
  );

  rce_engine #(.IDX_W(IDX_W), .FLAG_HI(FLAG_HI)) eng_i (
    .clk(clk), .rst_n(rst_n),
    .run_ok(tx_en && rx_en), .wb_en(wb_en),
    .tx_base(tx_base), .rx_base(rx_base),
    .cur_idx(tx_dma), .tx_cpu(tx_cpu), .rx_cpu(rx_cpu),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(eng_busy), .adv(eng_adv)
  );

  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(tx_en && rx_en)); // R9
  AST_START_NOT_RECLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(tx_dma != rx_cpu)); // R5

endmodule

// File: tb/ring_copy_engine_tb_top.sv
`timescale 1ns/1ps
module ring_copy_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        irq;

  logic        poke_we = 1'b0;
  logic [9:0]  poke_a = '0;
  logic [31:0] poke_d = '0;
  logic [31:0] mem [0:1023];

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ring_copy_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
  );

  // word memory, one cycle acknowledge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 32'h0;
      mem_ack <= 1'b0;
    end else begin
      if (poke_we) mem[poke_a] <= poke_d;
      else if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  function automatic logic [31:0] pat(int p, int e, int j);
    return {4'hA, 4'(p), 8'(e), 16'(j)};
  endfunction
  function automatic logic [31:0] sent(int p, int e, int j);
    return {4'hD, 4'(p), 8'(e), 16'(j)};
  endfunction
  function automatic logic [31:0] srcb(int p, int e);
    return ((p == 0) ? 32'h400 : 32'hA00) + 32'(e * 64);
  endfunction
  function automatic logic [31:0] dstb(int p, int e);
    return ((p == 0) ? 32'h800 : 32'hC00) + 32'(e * 64);
  endfunction
  function automatic logic [31:0] rdm(logic [31:0] a);
    return mem[a[11:2]];
  endfunction
  function automatic logic [31:0] donew(int nw);
    return (32'(nw * 4) << 16) | 32'h8000_0000;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    poke_we = 1'b1; poke_a = a[11:2]; poke_d = d;
    @(negedge clk);
    poke_we = 1'b0;
  endtask

  task automatic prep(input int p, input int e, input int nw, input logic [31:0] flags,
                      input logic [31:0] rxw1);
    poke(32'(e * 16), srcb(p, e));
    poke(32'(e * 16 + 4), (32'(nw * 4) << 16) | flags);
    poke(32'h100 + 32'(e * 16), dstb(p, e));
    poke(32'h104 + 32'(e * 16), rxw1);
    for (int j = 0; j < nw; j++) poke(srcb(p, e) + 32'(4 * j), pat(p, e, j));
    for (int j = 0; j <= nw; j++) poke(dstb(p, e) + 32'(4 * j), sent(p, e, j));
  endtask

  task automatic vchk(input string tag, input int p, input int e, input int nw,
                      input logic [31:0] w1);
    for (int j = 0; j < nw; j++) chk({tag, " R3 data"}, rdm(dstb(p, e) + 32'(4 * j)), pat(p, e, j));
    chk({tag, " R3 sentinel"}, rdm(dstb(p, e) + 32'(4 * nw)), sent(p, e, nw));
    chk({tag, " R6 rx word1"}, rdm(32'h104 + 32'(e * 16)), w1);
  endtask

  task automatic wait_idx(input int t);
    logic [31:0] d, g;
    bit ok = 1'b0;
    for (int k = 0; k < 4000 && !ok; k++) begin
      rd(12'h00C, d);
      rd(12'h204, g);
      if (d == 32'(t) && g[1] == 1'b0) ok = 1'b1;
    end
    if (!ok) chk("R4 wait for DMA index", d, 32'(t));
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(12'h204, d); chk("R1 ctrl", d, 0);
    rd(12'h00C, d); chk("R1 tx dma", d, 0);
    rd(12'h10C, d); chk("R1 rx dma", d, 0);
    rd(12'h220, d); chk("R1 status", d, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_req", 32'(mem_req), 0);

    // R2: configuration and readback
    wr(12'h000, 32'h0000_0000);
    wr(12'h100, 32'h0000_0100);
    wr(12'h004, 8); wr(12'h104, 8);
    wr(12'h108, 7);
    wr(12'h228, 32'h0001_0000);
    wr(12'h204, 32'h0000_047F);
    rd(12'h204, d); chk("R2 ctrl readback, busy bits read-only", d, 32'h0000_0475);
    rd(12'h100, d); chk("R2 rx base", d, 32'h100);
    rd(12'h104, d); chk("R2 rx count", d, 8);
    rd(12'h108, d); chk("R2 rx cpu", d, 7);

    // R3/R7 sweep: slot k carries k words, odd slots carry junk flags
    for (int k = 0; k < 7; k++)
      prep(0, k, k, (k % 2 == 1) ? 32'h4000_00F3 : 32'h0, 32'h0);
    wr(12'h008, 7);
    wait_idx(7);
    for (int k = 0; k < 7; k++) vchk((k % 2 == 1) ? "R7 sweep" : "sweep", 0, k, k, donew(k));
    rd(12'h10C, d); chk("R4 rx dma", d, 7);

    // R8: status and interrupt
    rd(12'h220, d); chk("R8 status set", d, 32'h0001_0000);
    chk("R8 irq high", 32'(irq), 1);
    wr(12'h228, 0);
    #1 chk("R8 irq masked", 32'(irq), 0);
    wr(12'h228, 32'h0001_0000);
    wr(12'h220, 32'h0001_0000);
    rd(12'h220, d); chk("R8 status cleared", d, 0);
    chk("R8 irq after clear", 32'(irq), 0);

    // R4/R5: wrap with a held-back slot
    prep(1, 7, 2, 0, 0); prep(1, 0, 2, 0, 0); prep(1, 1, 2, 0, 0);
    prep(1, 2, 2, 0, 0); prep(1, 3, 2, 0, 0);
    wr(12'h108, 2);
    wr(12'h008, 4);
    wait_idx(2);
    repeat (100) @(negedge clk);
    rd(12'h00C, d); chk("R5 stop at rx cpu", d, 2);
    chk("R5 held slot untouched", rdm(dstb(1, 2)), sent(1, 2, 0));
    vchk("R4 wrap slot7", 1, 7, 2, donew(2));
    vchk("R4 wrap slot0", 1, 0, 2, donew(2));
    vchk("R4 wrap slot1", 1, 1, 2, donew(2));
    wr(12'h108, 0);
    wait_idx(4);
    vchk("R4 slot2", 1, 2, 2, donew(2));
    vchk("R4 slot3", 1, 3, 2, donew(2));
    rd(12'h10C, d); chk("R4 rx dma after wrap", d, 4);

    // R9: disabled engine fetches nothing
    wr(12'h204, 32'h0000_0040);
    prep(2, 4, 3, 0, 0);
    wr(12'h008, 5);
    repeat (200) @(negedge clk);
    rd(12'h00C, d); chk("R9 no fetch when disabled", d, 4);
    chk("R9 dest untouched", rdm(dstb(2, 4)), sent(2, 4, 0));
    wr(12'h204, 32'h0000_0045);
    wait_idx(5);
    vchk("R9 after enable", 2, 4, 3, donew(3));

    // R9: disable during a long slot
    prep(2, 5, 15, 0, 0);
    prep(2, 6, 2, 0, 0);
    wr(12'h008, 7);
    d = 0;
    for (int k = 0; k < 50 && d[1] == 1'b0; k++) rd(12'h204, d);
    chk("R9 busy seen", 32'(d[1]), 1);
    wr(12'h204, 32'h0000_0040);
    wait_idx(6);
    repeat (150) @(negedge clk);
    rd(12'h00C, d); chk("R9 in-flight slot finished, next not fetched", d, 6);
    vchk("R9 in-flight slot", 2, 5, 15, donew(15));
    chk("R9 next slot untouched", rdm(dstb(2, 6)), sent(2, 6, 0));

    // R6: writeback off
    prep(2, 7, 3, 0, 32'h1234_5678);
    wr(12'h204, 32'h0000_0005);
    wr(12'h008, 0);
    wait_idx(0);
    vchk("R6 wb off slot6", 2, 6, 2, 32'h0);
    vchk("R6 wb off slot7", 2, 7, 3, 32'h1234_5678);

    // R10: index reset
    wr(12'h108, 7);
    wr(12'h204, 32'h0000_0045);
    prep(3, 0, 1, 0, 0);
    wr(12'h008, 1);
    wait_idx(1);
    vchk("R10 setup", 3, 0, 1, donew(1));
    wr(12'h208, 32'h0000_0001);
    rd(12'h00C, d); chk("R10 tx dma reset", d, 0);
    rd(12'h10C, d); chk("R10 rx dma kept", d, 1);
    wr(12'h208, 32'h0001_0000);
    rd(12'h10C, d); chk("R10 rx dma reset", d, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule